// File: doc/BRIEF.md
# Symmetric Distributed-Arithmetic Low-Pass FIR

This block is a single-rate, 35-tap low-pass FIR filter for an 80 MHz sample stream. The passband edge sits at 3 MHz, so a tone at 1 MHz passes and one at 10 MHz is strongly attenuated. The filter accepts at most one signed 12-bit sample per clock and returns one signed 16-bit filtered sample for each accepted input.

No multipliers are used. The coefficient set is symmetric, so each pair of taps that sit the same distance from the centre is summed first. This leaves 18 unique positions. For each bit weight of the pre-added words, small constant tables return the sum of the coefficients whose inputs carry a one in that bit. These per-bit sums are shifted, added, and the most significant bit is subtracted. The full-precision result is rounded by dropping its 13 low bits. All 13 bit slices work side by side, so the filter takes a new sample every cycle.

Both edges of the stream are valid/ready. An input is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the sink is taking its word in the same cycle. A sink that holds `out_ready` low freezes the whole pipe, including the delay line.

Top module: `fir_da_lowpass`

## Requirements
- R1: A synchronous reset clears the delay line and both pipeline valid flags. On the first cycle after reset, `out_valid` is low and `in_ready` is high. After a reset in the middle of a stream, the next outputs are computed as if every earlier sample were zero.
- R2: A sample enters the delay line only on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. The block emits exactly one output word for each accepted sample.
- R3: With `out_ready` held high, a sample accepted on one rising edge gives `out_valid` high after the next rising edge. It is not high before that.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values and `in_ready` is low. Any sample offered during the stall is not taken.
- R5: A cycle in which the pipe advances with `in_valid` low does not shift the delay line. It produces no output word two edges later.
- R6: Each output equals floor((S + 4096) / 8192) as a signed 16-bit value. S is the sum over i = 0..34 of h[i]·x[n-i], where x[n] is the newest accepted sample and x[n-i] is the sample accepted i acceptances earlier. This is rounding half up of S/2^13, and no high bits are lost.
- R7: The taps are symmetric, h[i] = h[34-i]. For i = 0..17 they are 0, -4, -11, -12, 12, 87, 246, 529, 972, 1602, 2420, 3403, 4492, 5603, 6628, 7460, 8002, 8191 (the centre tap). The state starts at zero. A single sample A followed by zeros then yields output k = floor((A·h[k] + 4096)/8192) for k = 0..34, and 0 after that.
- R8: After 35 or more accepted copies of a constant x, the output settles to floor((x·91049 + 4096)/8192). The value 91049 is the sum of all taps. For x = 2047 this is 22751, and for x = -2048 it is -22762.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 12 | Signed input sample |
| in_valid | input | 1 | `in_data` is offered this cycle |
| in_ready | output | 1 | The filter takes the offered sample on this edge |
| out_data | output | 16 | Signed, rounded filter output |
| out_valid | output | 1 | `out_data` holds a new result |
| out_ready | input | 1 | The sink takes `out_data` on this edge |

## Verification
The properties assume that `in_valid` and `out_ready` are known, never X, on every rising edge after reset. They also assume that reset is held for at least one edge, so the latency and bubble properties always look back over cycles of normal operation. The stimulus changes these inputs only on the falling edge, always to defined values. Stalls, gaps and resets are all driven through the ports, never by forcing state. Random samples cover the full 12-bit range, with the extremes 2047 and -2048 injected often, so the widest partial sums and the largest output swing both occur.

// File: rtl/fir_da_pkg.sv
`timescale 1ns/1ps
package fir_da_pkg;
  // Tap count and coefficient word size are tied to the constant set below.
  localparam int NTAPS = 35;
  localparam int CW    = 14;
  localparam int NUNIQ = (NTAPS + 1) / 2;

  // Unique coefficient by position: 0 is the outermost tap, NUNIQ-1 the centre.
  function automatic int coef_at(int k);
    int v;
    case (k)
      0:  v = 0;
      1:  v = -4;
      2:  v = -11;
      3:  v = -12;
      4:  v = 12;
      5:  v = 87;
      6:  v = 246;
      7:  v = 529;
      8:  v = 972;
      9:  v = 1602;
      10: v = 2420;
      11: v = 3403;
      12: v = 4492;
      13: v = 5603;
      14: v = 6628;
      15: v = 7460;
      16: v = 8002;
      17: v = 8191;
      default: v = 0;
    endcase
    return v;
  endfunction

  // One table entry: the sum of the coefficients whose select bit is set.
  function automatic int group_sum(int base, int nin, int sel);
    int s;
    s = 0;
    for (int j = 0; j < nin; j++)
      if (((sel >> j) & 1) == 1) s += coef_at(base + j);
    return s;
  endfunction
endpackage

// File: rtl/fir_da_lut.sv
`timescale 1ns/1ps
module fir_da_lut #(
  parameter int BASE = 0,
  parameter int NIN  = 3,
  parameter int LW   = 16
) (
  input  logic [NIN-1:0]       addr,
  output logic signed [LW-1:0] val
);
  localparam int DEPTH = 1 << NIN;

  logic signed [LW-1:0] table_w [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam int ENT = fir_da_pkg::group_sum(BASE, NIN, e);
    assign table_w[e] = LW'(ENT);
  end

  assign val = table_w[addr];
endmodule

// File: rtl/fir_da_slice.sv
`timescale 1ns/1ps
module fir_da_slice #(
  parameter int NU  = 18,
  parameter int NIN = 3,
  parameter int LW  = 16,
  parameter int PW  = 19
) (
  input  logic [NU-1:0]        bits,
  output logic signed [PW-1:0] sum
);
  localparam int NG   = (NU + NIN - 1) / NIN;
  localparam int PADW = NG * NIN;

  logic [PADW-1:0]      padded;
  logic signed [LW-1:0] part [NG];

  assign padded = PADW'(bits);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    fir_da_lut #(.BASE(g * NIN), .NIN(NIN), .LW(LW)) u_lut (
      .addr (padded[g*NIN +: NIN]),
      .val  (part[g])
    );
  end

  always_comb begin
    sum = '0;
    for (int g = 0; g < NG; g++)
      sum = sum + {{(PW-LW){part[g][LW-1]}}, part[g]};
  end
endmodule

// File: rtl/fir_da_lowpass.sv
`timescale 1ns/1ps
module fir_da_lowpass #(
  parameter int XW     = 12,
  parameter int OW     = 16,
  parameter int DROP   = 13,
  parameter int LUT_IN = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [XW-1:0] in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic signed [OW-1:0] out_data,
  output logic                 out_valid,
  input  logic                 out_ready
);
  import fir_da_pkg::*;

  localparam int NU = NUNIQ;
  localparam int SW = XW + 1;                       // pre-added word width
  localparam int NG = (NU + LUT_IN - 1) / LUT_IN;
  localparam int LW = CW + $clog2(LUT_IN + 1);      // one table output
  localparam int PW = LW + $clog2(NG + 1);          // one bit-slice sum
  localparam int AW = PW + SW + 1;                  // full-precision result

  logic signed [XW-1:0] tap [NTAPS];
  logic                 line_vld;
  logic                 adv;

  logic signed [SW-1:0] pre [NU];
  logic [NU-1:0]        bitcol [SW];
  logic signed [PW-1:0] psum [SW];
  logic signed [AW-1:0] acc, term, rnd;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Symmetric pre-add; an odd tap count leaves the centre tap alone.
  for (genvar k = 0; k < NU; k++) begin : g_pre
    if (2 * k == NTAPS - 1) begin : g_mid
      assign pre[k] = {tap[k][XW-1], tap[k]};
    end else begin : g_pair
      assign pre[k] = {tap[k][XW-1], tap[k]} +
                      {tap[NTAPS-1-k][XW-1], tap[NTAPS-1-k]};
    end
  end

  // Regroup so that each slice sees one bit weight of every position.
  always_comb begin
    for (int b = 0; b < SW; b++)
      for (int k = 0; k < NU; k++)
        bitcol[b][k] = pre[k][b];
  end

  for (genvar b = 0; b < SW; b++) begin : g_slice
    fir_da_slice #(.NU(NU), .NIN(LUT_IN), .LW(LW), .PW(PW)) u_slice (
      .bits (bitcol[b]),
      .sum  (psum[b])
    );
  end

  // Shift-and-add over bit weights; the sign weight is subtracted.
  always_comb begin
    acc  = '0;
    term = '0;
    for (int b = 0; b < SW; b++) begin
      term = {{(AW-PW){psum[b][PW-1]}}, psum[b]} << b;
      if (b == SW - 1) acc = acc - term;
      else             acc = acc + term;
    end
    rnd = acc + AW'(1 << (DROP - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) tap[i] <= '0;
      line_vld  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      if (in_valid) begin
        tap[0] <= in_data;
        for (int i = 1; i < NTAPS; i++) tap[i] <= tap[i-1];
      end
      line_vld  <= in_valid;
      out_valid <= line_vld;
      if (line_vld) out_data <= rnd[DROP+OW-1:DROP];
    end
  end
endmodule

// File: rtl/fir_da_lowpass_chk.sv
`timescale 1ns/1ps
module fir_da_lowpass_chk #(
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R3
  rise_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 in_ready |=> out_valid);

  // R5
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) ##1 in_ready |=> !out_valid);
endmodule

bind fir_da_lowpass fir_da_lowpass_chk #(.OW(OW)) u_chk (.*);

// File: tb/fir_da_lowpass_bench.sv
`timescale 1ns/1ps
module fir_da_lowpass_bench;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [11:0] in_data = '0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [15:0] out_data;
  logic               out_valid;
  logic               out_ready = 1'b0;

  always #5 clk = ~clk;

  fir_da_lowpass u_fir_da_lowpass (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  int errors = 0;
  int checks = 0;
  int hist [35];
  int exp_q [$];
  int imp_idx = -1;
  int imp_amp = 0;
  int last_out = 0;
  bit done = 0;

  function automatic int hcoef(int i);
    int k;
    int t [18] = '{0, -4, -11, -12, 12, 87, 246, 529, 972, 1602, 2420,
                   3403, 4492, 5603, 6628, 7460, 8002, 8191};
    if (i < 0 || i > 34) return 0;
    k = (i <= 17) ? i : 34 - i;
    return t[k];
  endfunction

  function automatic int rhu(longint s);
    return int'((s + 64'sd4096) >>> 13);
  endfunction

  function automatic int conv();
    longint s = 0;
    for (int i = 0; i < 35; i++) s += longint'(hist[i]) * hcoef(i);
    return rhu(s);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Drive at the falling edge, settle, record both handshakes, then step.
  task automatic step(bit v, int d, bit rdy);
    int e;
    in_valid  = v;
    in_data   = d[11:0];
    out_ready = rdy;
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 extra output", int'(out_data), 0);
      end else begin
        e = exp_q.pop_front();
        check(int'(out_data) == e, "R6 convolution", int'(out_data), e);
        if (imp_idx >= 0) begin
          e = rhu(longint'(imp_amp) * hcoef(imp_idx));
          check(int'(out_data) == e, "R7 impulse tap", int'(out_data), e);
          imp_idx++;
        end
      end
      last_out = int'(out_data);
    end
    if (in_valid && in_ready) begin
      for (int i = 34; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = d;
      exp_q.push_back(conv());
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b0;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    for (int i = 0; i < 35; i++) hist[i] = 0;
    exp_q.delete();
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b1);
  endtask

  function automatic int pick_sample();
    int r = $urandom_range(0, 9);
    if (r == 0) return 2047;
    if (r == 1) return -2048;
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  initial begin
    int held;
    void'($urandom(32'h5EED));
    @(negedge clk);
    do_reset();

    // R3: latency of one cycle past the accepting edge
    step(1'b1, 100, 1'b1);
    check(out_valid == 1'b0, "R3 early valid", int'(out_valid), 0);
    step(1'b0, 0, 1'b1);
    check(out_valid == 1'b1, "R3 valid after next edge", int'(out_valid), 1);
    drain();

    // R7: positive and negative impulses, tap by tap
    do_reset();
    imp_amp = 2047; imp_idx = 0;
    step(1'b1, 2047, 1'b1);
    for (int i = 0; i < 40; i++) step(1'b1, 0, 1'b1);
    drain();
    imp_amp = -2048; imp_idx = 0;
    step(1'b1, -2048, 1'b1);
    for (int i = 0; i < 40; i++) step(1'b1, 0, 1'b1);
    drain();
    imp_idx = -1;

    // R8: settled DC values
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b1, 2047, 1'b1);
    drain();
    check(last_out == 22751, "R8 DC +2047", last_out, 22751);
    for (int i = 0; i < 40; i++) step(1'b1, -2048, 1'b1);
    drain();
    check(last_out == -22762, "R8 DC -2048", last_out, -22762);
    for (int i = 0; i < 40; i++) step(1'b1, -700, 1'b1);
    drain();
    check(last_out == rhu(-700 * 91049), "R8 DC -700", last_out, rhu(-700 * 91049));

    // R4: stall holds output and refuses input
    step(1'b1, 300, 1'b1);
    step(1'b1, -300, 1'b1);
    held = int'(out_data);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 999, 1'b0);
      check(out_valid == 1'b1, "R4 valid held", int'(out_valid), 1);
      check(int'(out_data) == held, "R4 data held", int'(out_data), held);
      check(in_ready == 1'b0, "R4 in_ready low in stall", int'(in_ready), 0);
    end
    drain();

    // R5: bubbles produce nothing
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 555, 1'b1);
      check(out_valid == 1'b0, "R5 no output on bubble", int'(out_valid), 0);
    end

    // Random traffic with gaps and back-pressure (R2, R6)
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 9) < 7, pick_sample(), $urandom_range(0, 9) < 8);

    // R1: reset mid-stream wipes history
    for (int i = 0; i < 10; i++) step(1'b1, pick_sample(), 1'b1);
    do_reset();
    for (int i = 0; i < 20; i++) step(1'b1, pick_sample(), $urandom_range(0, 3) != 0);
    for (int i = 0; i < 10; i++) step(1'b0, 0, 1'b1);
    check(exp_q.size() == 0, "R2 one output per input", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule